// File: doc/BRIEF.md
# USB Token Packet Decoder with CRC5 Check

This block sits behind a USB receiver that has already removed the line coding, stripped stuffed bits and found the start of packet. It takes in the packet bytes one at a time. It validates the PID byte against its complemented copy and sorts the packet into a class. For token packets it pulls out the device address and endpoint. For start-of-frame packets it pulls out the frame number. In both cases it checks the 5-bit CRC over the 11 payload bits.

The receiver marks the end of each packet with a one-cycle EOP strobe. One cycle later the block pulses `done_o` and presents the decoded fields and three error flags. Each byte is assembled with bus order in bit 0 first, so the first bit on the wire is bit 0 of the byte. A bare EOP that carries no bytes (such as a low-speed keep-alive) produces no result.

Top module: `usbtok_decoder`

## Requirements
- R1: The first byte after an idle/EOP is the PID byte. Bits [3:0] hold the PID and bits [7:4] must equal its bitwise inverse. On a mismatch, `pid_err_o`=1 and `pid_o`, `kind_o`, `addr_o`, `endp_o` and `frame_o` keep their previous values.
- R2: `kind_o` reports the class: 0 is a token (OUT 0001, IN 1001, SETUP 1101), 1 is SOF (0101), 2 is a handshake (ACK 0010, NAK 1010, STALL 1110, NYET 0110), and 3 is any other PID. Other PIDs get no length or CRC check.
- R3: For a token, `addr_o` = byte1[6:0] and `endp_o` = {byte2[2:0], byte1[7]}.
- R4: For SOF, `frame_o` = {byte2[2:0], byte1}. `addr_o` and `endp_o` are left unchanged.
- R5: The CRC uses the polynomial x^5+x^2+1 with an all-ones seed. It runs over the 11 payload bits in bus order, and the transmitted value is the inverted remainder. The CRC sits in byte2[7:3], and byte2[3] carries the inverted remainder MSb (the first CRC bit on the bus). The bytes 0x69, 0x9B, 0x70 form a valid IN token with address 0x1B and endpoint 1.
- R6: A token or SOF of correct length whose CRC does not match raises `crc_err_o`.
- R7: A token or SOF that is not exactly 3 bytes long raises `len_err_o`, with `crc_err_o`=0.
- R8: Handshakes are never CRC checked. They must be exactly 1 byte long, otherwise `len_err_o`=1.
- R9: `done_o` is a one-cycle pulse on the cycle after EOP. All outputs change only on cycles where `done_o` is high.
- R10: An EOP with no byte since the previous EOP gives no `done_o` and changes no output.
- R11: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | A received byte is present on byte_i |
| byte_i | input | 8 | Received byte, bit 0 first on the bus |
| eop_i | input | 1 | End-of-packet strobe |
| done_o | output | 1 | One-cycle pulse: packet result valid |
| pid_o | output | 4 | Last accepted PID |
| kind_o | output | 2 | Packet class (R2) |
| addr_o | output | 7 | Token device address |
| endp_o | output | 4 | Token endpoint |
| frame_o | output | 11 | SOF frame number |
| pid_err_o | output | 1 | PID check nibble mismatch |
| crc_err_o | output | 1 | CRC5 check failed |
| len_err_o | output | 1 | Wrong packet length |

## Verification
A byte counter that is off by one shows up at the next `done_o` as a false `len_err_o`, or as an address taken from the wrong byte. A wrong seed or a wrong feedback tap in the CRC chain flags every good token of the table in the same cycle. A stale packet-start flag would make a bare EOP pulse `done_o`, and that would be visible one cycle after the strobe. Holding the outputs on a PID error is checked by comparing the fields just before and just after such a pulse.

// File: rtl/usbtok_pkg.sv
package usbtok_pkg;
  typedef enum logic [1:0] {
    KIND_TOKEN  = 2'd0,
    KIND_SOF    = 2'd1,
    KIND_HSHAKE = 2'd2,
    KIND_OTHER  = 2'd3
  } pkt_kind_e;

  localparam logic [3:0] PID_OUT   = 4'b0001;
  localparam logic [3:0] PID_IN    = 4'b1001;
  localparam logic [3:0] PID_SETUP = 4'b1101;
  localparam logic [3:0] PID_SOF   = 4'b0101;
  localparam logic [3:0] PID_ACK   = 4'b0010;
  localparam logic [3:0] PID_NAK   = 4'b1010;
  localparam logic [3:0] PID_STALL = 4'b1110;
  localparam logic [3:0] PID_NYET  = 4'b0110;

  localparam int CRC_W = 5;
  localparam logic [CRC_W-1:0] CRC_POLY     = 5'b00101;
  localparam logic [CRC_W-1:0] CRC_SEED     = 5'b11111;
  localparam logic [CRC_W-1:0] CRC_RESIDUAL = 5'b01100;
endpackage

// File: rtl/usbtok_pid_class.sv
module usbtok_pid_class
  import usbtok_pkg::*;
(
  input  logic [7:0] pid_byte_i,
  output logic       pid_ok_o,
  output logic [3:0] pid_o,
  output logic [1:0] kind_o
);
  pkt_kind_e kind;

  assign pid_o    = pid_byte_i[3:0];
  assign pid_ok_o = (pid_byte_i[7:4] == ~pid_byte_i[3:0]);

  always_comb begin
    unique case (pid_byte_i[3:0])
      PID_OUT, PID_IN, PID_SETUP:            kind = KIND_TOKEN;
      PID_SOF:                               kind = KIND_SOF;
      PID_ACK, PID_NAK, PID_STALL, PID_NYET: kind = KIND_HSHAKE;
      default:                               kind = KIND_OTHER;
    endcase
  end

  assign kind_o = kind;
endmodule

// File: rtl/usbtok_crc5_chain.sv
// Bit-serial CRC unrolled over the whole token payload, bus order = index order.
module usbtok_crc5_chain
  import usbtok_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] data_i,
  output logic              residual_ok_o
);
  logic [CRC_W-1:0] chain [DATA_W+1];

  assign chain[0] = CRC_SEED;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic fb;
    assign fb = data_i[i] ^ chain[i][CRC_W-1];
    assign chain[i+1] = {chain[i][CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  end

  assign residual_ok_o = (chain[DATA_W] == CRC_RESIDUAL);
endmodule

// File: rtl/usbtok_decoder.sv
module usbtok_decoder
  import usbtok_pkg::*;
#(
  parameter int ADDR_W       = 7,
  parameter int ENDP_W       = 4,
  parameter int TOKEN_BYTES  = 3,
  parameter int HSHAKE_BYTES = 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      byte_valid_i,
  input  logic [7:0]                byte_i,
  input  logic                      eop_i,
  output logic                      done_o,
  output logic [3:0]                pid_o,
  output logic [1:0]                kind_o,
  output logic [ADDR_W-1:0]         addr_o,
  output logic [ENDP_W-1:0]         endp_o,
  output logic [ADDR_W+ENDP_W-1:0]  frame_o,
  output logic                      pid_err_o,
  output logic                      crc_err_o,
  output logic                      len_err_o
);
  localparam int FRAME_W = ADDR_W + ENDP_W;
  localparam int PAY_W   = 8 * (TOKEN_BYTES - 1);
  localparam int CNT_MAX = TOKEN_BYTES + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       pid_byte_q;
  logic [PAY_W-1:0] pay_q;

  logic       pid_ok, crc_ok, len_ok, pkt_end, is_tok;
  logic [3:0] pid_c;
  logic [1:0] kind_c;

  usbtok_pid_class u_pid (
    .pid_byte_i (pid_byte_q),
    .pid_ok_o   (pid_ok),
    .pid_o      (pid_c),
    .kind_o     (kind_c)
  );

  usbtok_crc5_chain #(.DATA_W(PAY_W)) u_crc (
    .data_i        (pay_q),
    .residual_ok_o (crc_ok)
  );

  // byte capture; a byte coinciding with EOP is dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      pid_byte_q <= '0;
      pay_q      <= '0;
    end else if (eop_i) begin
      cnt_q <= '0;
    end else if (byte_valid_i) begin
      if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
      if (cnt_q == '0) begin
        pid_byte_q <= byte_i;
        pay_q      <= '0;
      end else if (cnt_q < CNT_W'(TOKEN_BYTES)) begin
        pay_q[(int'(cnt_q) - 1) * 8 +: 8] <= byte_i;
      end
    end
  end

  assign pkt_end = eop_i && (cnt_q != '0);
  assign is_tok  = (kind_c == KIND_TOKEN) || (kind_c == KIND_SOF);

  always_comb begin
    unique case (kind_c)
      KIND_TOKEN, KIND_SOF: len_ok = (cnt_q == CNT_W'(TOKEN_BYTES));
      KIND_HSHAKE:          len_ok = (cnt_q == CNT_W'(HSHAKE_BYTES));
      default:              len_ok = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      pid_o     <= '0;
      kind_o    <= '0;
      addr_o    <= '0;
      endp_o    <= '0;
      frame_o   <= '0;
      pid_err_o <= 1'b0;
      crc_err_o <= 1'b0;
      len_err_o <= 1'b0;
    end else begin
      done_o <= pkt_end;
      if (pkt_end) begin
        pid_err_o <= !pid_ok;
        if (pid_ok) begin
          pid_o     <= pid_c;
          kind_o    <= kind_c;
          len_err_o <= !len_ok;
          crc_err_o <= is_tok && len_ok && !crc_ok;
          if (kind_c == KIND_TOKEN) begin
            addr_o <= pay_q[ADDR_W-1:0];
            endp_o <= pay_q[FRAME_W-1:ADDR_W];
          end
          if (kind_c == KIND_SOF) frame_o <= pay_q[FRAME_W-1:0];
        end else begin
          len_err_o <= 1'b0;
          crc_err_o <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/usbtok_decoder_chk.sv
module usbtok_decoder_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        eop_i,
  input logic        done_o,
  input logic [3:0]  pid_o,
  input logic [1:0]  kind_o,
  input logic [6:0]  addr_o,
  input logic [3:0]  endp_o,
  input logic [10:0] frame_o,
  input logic        pid_err_o,
  input logic        crc_err_o,
  input logic        len_err_o
);
  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_eop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(eop_i));

  assert_fields_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(pid_o) && $stable(kind_o) && $stable(addr_o)
                 && $stable(endp_o) && $stable(frame_o)));

  assert_flags_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(pid_err_o) && $stable(crc_err_o) && $stable(len_err_o)));

  assert_pid_err_keeps_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pid_err_o) |-> ($stable(pid_o) && $stable(kind_o) && $stable(addr_o)
                               && $stable(endp_o) && $stable(frame_o)));

  assert_one_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pid_err_o, crc_err_o, len_err_o}));

  assert_hshake_no_crc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_o == 2'd2) |-> !crc_err_o);

  assert_sof_keeps_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !pid_err_o && kind_o == 2'd1) |-> ($stable(addr_o) && $stable(endp_o)));
endmodule

bind usbtok_decoder usbtok_decoder_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .eop_i     (eop_i),
  .done_o    (done_o),
  .pid_o     (pid_o),
  .kind_o    (kind_o),
  .addr_o    (addr_o),
  .endp_o    (endp_o),
  .frame_o   (frame_o),
  .pid_err_o (pid_err_o),
  .crc_err_o (crc_err_o),
  .len_err_o (len_err_o)
);

// File: tb/sim_usbtok_decoder.sv
`timescale 1ns/1ps
module sim_usbtok_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_d = '0;
  logic        eop = 1'b0;
  logic        done;
  logic [3:0]  pid;
  logic [1:0]  kind;
  logic [6:0]  addr;
  logic [3:0]  endp;
  logic [10:0] frame;
  logic        pid_err, crc_err, len_err;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  usbtok_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(byte_valid), .byte_i(byte_d), .eop_i(eop),
    .done_o(done), .pid_o(pid), .kind_o(kind), .addr_o(addr), .endp_o(endp),
    .frame_o(frame), .pid_err_o(pid_err), .crc_err_o(crc_err), .len_err_o(len_err)
  );

  typedef struct packed {
    logic [3:0]  pid;
    logic        pid_bad;
    logic [10:0] pay;      // pay[0] is first on the bus
    logic        crc_bad;
    logic [2:0]  n;
    logic [1:0]  kind;
    logic        pe, ce, le;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{4'b1001, 1'b0, 11'b00010011011, 1'b0, 3'd3, 2'd0, 1'b0, 1'b0, 1'b0}, // IN
    '{4'b0001, 1'b0, 11'h5A3,         1'b0, 3'd3, 2'd0, 1'b0, 1'b0, 1'b0}, // OUT
    '{4'b1101, 1'b0, 11'h000,         1'b0, 3'd3, 2'd0, 1'b0, 1'b0, 1'b0}, // SETUP
    '{4'b0101, 1'b0, 11'h7FF,         1'b0, 3'd3, 2'd1, 1'b0, 1'b0, 1'b0}, // SOF
    '{4'b0101, 1'b0, 11'h2C4,         1'b0, 3'd3, 2'd1, 1'b0, 1'b0, 1'b0}, // SOF
    '{4'b1001, 1'b0, 11'h155,         1'b1, 3'd3, 2'd0, 1'b0, 1'b1, 1'b0}, // bad crc
    '{4'b0001, 1'b0, 11'h321,         1'b0, 3'd2, 2'd0, 1'b0, 1'b0, 1'b1}, // short
    '{4'b0101, 1'b0, 11'h0F0,         1'b0, 3'd4, 2'd1, 1'b0, 1'b0, 1'b1}, // long SOF
    '{4'b0010, 1'b0, 11'h000,         1'b0, 3'd1, 2'd2, 1'b0, 1'b0, 1'b0}, // ACK
    '{4'b1010, 1'b0, 11'h000,         1'b0, 3'd1, 2'd2, 1'b0, 1'b0, 1'b0}, // NAK
    '{4'b1110, 1'b0, 11'h000,         1'b0, 3'd1, 2'd2, 1'b0, 1'b0, 1'b0}, // STALL
    '{4'b0110, 1'b0, 11'h3A5,         1'b1, 3'd2, 2'd2, 1'b0, 1'b0, 1'b1}, // long NYET
    '{4'b1001, 1'b1, 11'h066,         1'b0, 3'd3, 2'd0, 1'b1, 1'b0, 1'b0}, // pid err
    '{4'b0011, 1'b0, 11'h123,         1'b1, 3'd3, 2'd3, 1'b0, 1'b0, 1'b0}, // DATA0
    '{4'b0010, 1'b1, 11'h000,         1'b0, 3'd1, 2'd2, 1'b1, 1'b0, 1'b0}  // bad ACK
  };

  // reference model state (from requirements)
  logic [3:0]  m_pid = '0;
  logic [1:0]  m_kind = '0;
  logic [6:0]  m_addr = '0;
  logic [3:0]  m_endp = '0;
  logic [10:0] m_frame = '0;

  task automatic chk(input logic ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  function automatic logic [4:0] crc_bus(input logic [10:0] p);
    logic [4:0] r;
    logic [4:0] c;
    r = 5'h1F;
    for (int i = 0; i < 11; i++) begin
      logic fb;
      fb = p[i] ^ r[4];
      r = {r[3:0], 1'b0} ^ (fb ? 5'b00101 : 5'b00000);
    end
    for (int i = 0; i < 5; i++) c[i] = ~r[4-i];
    return c;
  endfunction

  task automatic send(input logic [7:0] b0, b1, b2, b3, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byte_valid = 1'b1;
      byte_d = (i == 0) ? b0 : (i == 1) ? b1 : (i == 2) ? b2 : b3;
    end
    @(negedge clk);
    byte_valid = 1'b0;
    eop = 1'b1;
    @(negedge clk);
    eop = 1'b0;
  endtask

  task automatic check_model(input string tag);
    chk(pid == m_pid,     {tag, " R1/R2 pid"},  pid,   m_pid);
    chk(kind == m_kind,   {tag, " R2 kind"},    kind,  m_kind);
    chk(addr == m_addr,   {tag, " R3 addr"},    addr,  m_addr);
    chk(endp == m_endp,   {tag, " R3 endp"},    endp,  m_endp);
    chk(frame == m_frame, {tag, " R4 frame"},   frame, m_frame);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R9 actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    logic [7:0] b0, b1, b2;
    logic [4:0] c;
    logic [7:0] rb1, rb2;

    repeat (3) @(negedge clk);
    chk({done, pid, kind, addr, endp, frame, pid_err, crc_err, len_err} == '0,
        "R11 reset outputs", int'(addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({done, pid, kind, addr, endp, frame, pid_err, crc_err, len_err} == '0,
        "R11 after release", int'(frame), 0);

    // literal captured IN token
    send(8'h69, 8'h9B, 8'h70, 8'h00, 3);
    chk(done == 1'b1, "R9 done after EOP", done, 1);
    chk(crc_err == 1'b0 && pid_err == 1'b0 && len_err == 1'b0, "R5 captured IN valid",
        {pid_err, crc_err, len_err}, 0);
    m_pid = 4'b1001; m_kind = 2'd0; m_addr = 7'h1B; m_endp = 4'd1;
    check_model("R5 captured IN");
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", done, 0);

    foreach (VECS[k]) begin
      vec_t v;
      v  = VECS[k];
      c  = crc_bus(v.pay);
      if (v.crc_bad) c[0] = ~c[0];
      b0 = {~v.pid, v.pid};
      if (v.pid_bad) b0[7] = ~b0[7];
      b1 = v.pay[7:0];
      b2 = {c, v.pay[10:8]};
      send(b0, b1, b2, 8'hA5, int'(v.n));
      rb1 = (v.n > 1) ? b1 : 8'h00;
      rb2 = (v.n > 2) ? b2 : 8'h00;
      if (!v.pe) begin
        m_pid = v.pid; m_kind = v.kind;
        if (v.kind == 2'd0) begin
          m_addr = rb1[6:0];
          m_endp = {rb2[2:0], rb1[7]};
        end
        if (v.kind == 2'd1) m_frame = {rb2[2:0], rb1};
      end
      chk(done == 1'b1,      $sformatf("vec%0d R9 done", k),       done,    1);
      chk(pid_err == v.pe,   $sformatf("vec%0d R1 pid_err", k),    pid_err, v.pe);
      chk(crc_err == v.ce,   $sformatf("vec%0d R5/R6 crc_err", k), crc_err, v.ce);
      chk(len_err == v.le,   $sformatf("vec%0d R7/R8 len_err", k), len_err, v.le);
      check_model($sformatf("vec%0d", k));
      @(negedge clk);
      chk(done == 1'b0, $sformatf("vec%0d R9 pulse width", k), done, 0);
    end

    // bare EOP: no result, nothing moves
    @(negedge clk);
    eop = 1'b1;
    @(negedge clk);
    eop = 1'b0;
    chk(done == 1'b0, "R10 bare EOP no done", done, 0);
    check_model("R10 bare EOP");
    chk(pid_err == 1'b1, "R10 flags held", pid_err, 1);
    repeat (2) @(negedge clk);
    chk(done == 1'b0, "R10 no late done", done, 0);

    // back-to-back good tokens with no idle gap
    c = crc_bus(11'h4CD);
    send({~4'b1001, 4'b1001}, 8'hCD, {c, 3'b100}, 8'h00, 3);
    m_pid = 4'b1001; m_kind = 2'd0; m_addr = 7'h4D; m_endp = 4'b1001;
    chk(crc_err == 1'b0 && pid_err == 1'b0, "R6 good token after errors", crc_err, 0);
    check_model("R3 back-to-back");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule